// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Read Handshake

This block pairs a requesting side and a responding side that complete one read over a request/acknowledge handshake that assumes no common clock. Both sides are modelled with a clock, but neither trusts the other's timing. Each side passes the other's handshake line through a two-flop synchronizer. Each side also moves only after it has seen the partner's previous edge.

A start pulse makes the requester drive an address and a direction qualifier onto the bus. The requester holds both unchanged for a programmable settling interval and then raises the request line. The responder decodes the address and turns on its data drivers with the decoded word. One cycle later it raises acknowledge. The requester captures the word and drops the request line. The responder sees the request fall, then drops acknowledge and releases the data lines. When the requester sees acknowledge low, it pulses done and accepts the next start.

Top module: `hs_rd_pair`

## Requirements
- R1: After reset, bus_req_o, bus_ack_o, bus_oe_o, done_o and busy_o are low, and rd_data_o and bus_data_o are zero.
- R2: A start accepted at a clock edge places addr_i and dir_i on bus_addr_o and bus_dir_o. bus_req_o rises exactly DECODE_CYCLES edges later. Address and direction stay unchanged until the next accepted start.
- R3: The requester raises bus_req_o only while its synchronized copy of acknowledge is low.
- R4: The responder's word is (addr zero-extended × DATA_MULT mod 2^DW) XOR (all ones when dir is 1). bus_oe_o is high, with the word on bus_data_o, for at least one cycle before bus_ack_o rises.
- R5: The responder raises bus_ack_o only after its synchronized request is high. bus_data_o and bus_oe_o stay stable while bus_ack_o is high.
- R6: The requester drops bus_req_o only after its synchronized acknowledge is high, and captures the word into rd_data_o at that edge.
- R7: The responder drops bus_ack_o and bus_oe_o only after its synchronized request is low. bus_oe_o is still high in the cycle in which bus_req_o falls.
- R8: done_o pulses for exactly one cycle after the requester sees acknowledge low. busy_o falls in the same cycle, and bus_ack_o and bus_oe_o are already low.
- R9: A start that arrives while busy_o is high is ignored. The bus address does not change, no extra done_o pulse appears, and rd_data_o carries the word of the original address.
- R10: A start in the cycle after done_o is accepted and completes a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both sides |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a read (taken only when idle) |
| addr_i | input | AW | Address for the read |
| dir_i | input | 1 | Direction qualifier that the responder decodes |
| rd_data_o | output | DW | Captured read word |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Requester is not idle |
| bus_req_o | output | 1 | Request line, requester to responder |
| bus_ack_o | output | 1 | Acknowledge line, responder to requester |
| bus_addr_o | output | AW | Address lines driven by the requester |
| bus_dir_o | output | 1 | Direction line driven by the requester |
| bus_data_o | output | DW | Data lines, zero when not driven |
| bus_oe_o | output | 1 | Responder data-drive enable |

## Verification
The hardest case to reach is a fresh start that arrives while a handshake is mid-flight, because it must leave the bus address and the result untouched. The driver pulses start with a different address and direction after the request has risen. The scoreboard then confirms that only the original word returns and that exactly one done appears. A second hard case is the window in which request has fallen but the responder has not yet seen it. The driver samples the enable in the cycle in which request first reads low, to show that the data is still driven.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE,
    M_DECODE,
    M_REQ,
    M_RELEASE
  } m_state_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_DRIVE,
    S_ACK
  } s_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master import hs_pkg::*; #(
  parameter int AW            = 8,
  parameter int DW            = 16,
  parameter int DECODE_CYCLES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dir_i,
  input  logic          ack_i,
  input  logic [DW-1:0] data_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          busy_o
);
  localparam int CW = $clog2(DECODE_CYCLES + 1) + 1;

  m_state_e      state_q;
  logic [CW-1:0] cnt_q;
  logic          ack_s;

  hs_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= M_IDLE;
      cnt_q     <= '0;
      req_o     <= 1'b0;
      addr_o    <= '0;
      dir_o     <= 1'b0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        M_IDLE: if (start_i && !ack_s) begin
          addr_o  <= addr_i;
          dir_o   <= dir_i;
          cnt_q   <= '0;
          state_q <= M_DECODE;
        end
        M_DECODE: begin
          // settle window: address held before request
          if (cnt_q == CW'(DECODE_CYCLES - 1)) begin
            req_o   <= 1'b1;
            state_q <= M_REQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        M_REQ: if (ack_s) begin
          rd_data_o <= data_i;
          req_o     <= 1'b0;
          state_q   <= M_RELEASE;
        end
        M_RELEASE: if (!ack_s) begin
          done_o  <= 1'b1;
          state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != M_IDLE);

  // age of the current address/direction on the bus, for the settle check
  logic [AW:0]   prev_q;
  logic [CW-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      age_q  <= '0;
    end else begin
      prev_q <= {dir_o, addr_o};
      if ({dir_o, addr_o} != prev_q) age_q <= '0;
      else if (age_q != {CW{1'b1}})  age_q <= age_q + 1'b1;
    end
  end

  AST_SETTLE_BEFORE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (int'(age_q) >= DECODE_CYCLES - 1)); // R2
  AST_ADDR_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(dir_o))); // R2
  AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(ack_s)); // R3
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(ack_s)); // R6
  AST_DONE_AFTER_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!$past(ack_s) && !busy_o)); // R8
endmodule

// File: rtl/hs_slave.sv
module hs_slave import hs_pkg::*; #(
  parameter int          AW          = 8,
  parameter int          DW          = 16,
  parameter logic [DW-1:0] DATA_MULT = 16'h9E37,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dir_i,
  output logic          ack_o,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  s_state_e      state_q;
  logic [DW-1:0] word_q;
  logic [DW-1:0] word_d;
  logic          req_s;

  hs_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  always_comb word_d = (DW'(addr_i) * DATA_MULT) ^ {DW{dir_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      ack_o   <= 1'b0;
      oe_o    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_s) begin
          word_q  <= word_d;
          oe_o    <= 1'b1;
          state_q <= S_DRIVE;
        end
        S_DRIVE: begin
          // data has been on the lines one cycle before ack
          ack_o   <= 1'b1;
          state_q <= S_ACK;
        end
        S_ACK: if (!req_s) begin
          ack_o   <= 1'b0;
          oe_o    <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign data_o = oe_o ? word_q : '0;

  AST_OE_BEFORE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(oe_o)); // R4
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_s, 2)); // R5
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> ($stable(data_o) && oe_o)); // R5
  AST_RELEASE_AFTER_REQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (!$past(req_s) && !oe_o)); // R7
endmodule

// File: rtl/hs_rd_pair.sv
module hs_rd_pair #(
  parameter int            AW            = 8,
  parameter int            DW            = 16,
  parameter int            DECODE_CYCLES = 2,
  parameter logic [DW-1:0] DATA_MULT     = 16'h9E37
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dir_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          bus_req_o,
  output logic          bus_ack_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_dir_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_oe_o
);
  localparam int SYNC_STAGES = 2;

  hs_master #(
    .AW(AW), .DW(DW), .DECODE_CYCLES(DECODE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) i_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .addr_i   (addr_i),
    .dir_i    (dir_i),
    .ack_i    (bus_ack_o),
    .data_i   (bus_data_o),
    .req_o    (bus_req_o),
    .addr_o   (bus_addr_o),
    .dir_o    (bus_dir_o),
    .rd_data_o(rd_data_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  hs_slave #(
    .AW(AW), .DW(DW), .DATA_MULT(DATA_MULT), .SYNC_STAGES(SYNC_STAGES)
  ) i_slave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (bus_req_o),
    .addr_i(bus_addr_o),
    .dir_i (bus_dir_o),
    .ack_o (bus_ack_o),
    .data_o(bus_data_o),
    .oe_o  (bus_oe_o)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!bus_ack_o && !bus_oe_o && !bus_req_o)); // R8
endmodule

// File: tb/test_hs_rd_pair.sv
`timescale 1ns/1ps
module test_hs_rd_pair;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEC = 2;
  localparam logic [DW-1:0] MULT = 16'h9E37;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          dir = 1'b0;
  logic [DW-1:0] rd_data;
  logic          done, busy, req, ack, dir_bus, oe;
  logic [AW-1:0] addr_bus;
  logic [DW-1:0] data_bus;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_push = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  hs_rd_pair #(.AW(AW), .DW(DW), .DECODE_CYCLES(DEC), .DATA_MULT(MULT)) i_hs_rd_pair (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .dir_i(dir),
    .rd_data_o(rd_data), .done_o(done), .busy_o(busy),
    .bus_req_o(req), .bus_ack_o(ack), .bus_addr_o(addr_bus), .bus_dir_o(dir_bus),
    .bus_data_o(data_bus), .bus_oe_o(oe)
  );

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a, logic d);
    return (DW'(a) * MULT) ^ {DW{d}};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pop on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      chk(!busy, "R8 busy low at done", busy, 0);
      chk(!ack && !oe, "R8 ack/oe low at done", {ack, oe}, 0);
      if (exp_q.size() == 0) begin
        chk(0, "R9 unexpected done", n_done, n_push);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R6 rd_data", rd_data, e);
      end
    end
  end

  task automatic run_txn(logic [AW-1:0] a, logic d, bit poke);
    int n;
    bit seen_ack;
    @(negedge clk);
    chk(!busy, "R10 idle before start", busy, 0);
    start = 1'b1; addr = a; dir = d;
    exp_q.push_back(word_of(a, d));
    n_push++;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!req) begin
      chk(addr_bus == a && dir_bus == d, "R2 addr held in settle", addr_bus, a);
      chk(!ack, "R3 ack low before req", ack, 0);
      n++;
      @(negedge clk);
    end
    chk(n == DEC, "R2 settle cycles", n, DEC);
    if (poke) begin
      start = 1'b1; addr = ~a; dir = ~d;
      @(negedge clk);
      start = 1'b0;
      chk(addr_bus == a && dir_bus == d, "R9 addr unchanged", addr_bus, a);
    end
    seen_ack = 0;
    while (!ack) begin
      if (oe) chk(data_bus == word_of(a, d), "R4 data before ack", data_bus, word_of(a, d));
      @(negedge clk);
    end
    chk(oe && data_bus == word_of(a, d), "R4 word at ack", data_bus, word_of(a, d));
    chk(req, "R5 req high at ack rise", req, 1);
    while (req) begin
      chk(data_bus == word_of(a, d), "R5 data held", data_bus, word_of(a, d));
      @(negedge clk);
    end
    chk(oe, "R7 oe still high at req fall", oe, 1);
    chk(ack, "R7 ack still high at req fall", ack, 1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_done, n_push);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req && !ack && !oe && !done && !busy, "R1 control low",
        {req, ack, oe, done, busy}, 0);
    chk(rd_data == '0 && data_bus == '0, "R1 data zero", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(8'h00, 1'b0, 0);
    run_txn(8'hFF, 1'b0, 0);
    run_txn(8'h5A, 1'b1, 1);
    run_txn(8'h81, 1'b0, 1);
    // R10 back-to-back: run_txn starts at the negedge right after done
    run_txn(8'h3C, 1'b1, 0);
    run_txn(8'h3C, 1'b0, 0);
    repeat (10) @(negedge clk);
    chk(n_done == n_push, "R9 done count", n_done, n_push);
    chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule